// File: doc/BRIEF.md
# Oscillator Stabilization and Recovery Counter

This block holds the chip's internal bus clocks off while the oscillator settles. A 12-bit counter advances on every falling edge of the oscillator clock. After power-on it allows the bus clocks only once the counter has run a full 4096 cycles. When the part enters its low-power stop state, the counter is cleared and frozen. A later wake event starts a recovery count. The delay is the full 4096 cycles by default, or 32 cycles when the short-recovery option is set, which suits oscillators that start quickly.

Outside recovery the counter runs freely. Each time it wraps it emits a one-cycle tick, which a watchdog uses as a prescaled clock. Three sources can end stop: an interrupt, a break request and the external reset pin. The external reset only acts as a wake source. It never clears or disturbs the counter.

Top module: `osc_settle_timer`

## Requirements
- R1: While not in stop, the counter advances once per falling edge of `osc_clk`. `ovf_tick` is high for exactly one cycle after each wrap from 4095 to 0, so consecutive ticks are 4096 cycles apart.
- R2: After `por_rst` is released, `bus_clk_en` stays low for 4096 falling edges and rises on the 4096th. The value of `short_rec` has no effect on this delay.
- R3: A `stop_req` pulse while `bus_clk_en` is high clears the counter and drops `bus_clk_en` on that same falling edge.
- R4: In stop the counter is frozen, `ovf_tick` stays low and `bus_clk_en` stays low.
- R5: A wake event in stop with `short_rec` = 1 raises `bus_clk_en` on the 32nd falling edge after the edge that accepted the wake.
- R6: A wake event in stop with `short_rec` = 0 raises `bus_clk_en` on the 4096th falling edge after the wake edge. `ovf_tick` is high in the same cycle.
- R7: `short_rec` is captured on the wake edge. Later changes during recovery do not alter the delay.
- R8: A wake event on any source (`wake_irq`, `wake_brk`, `ext_rst`) that arrives outside stop is ignored. `bus_clk_en` stays high and the tick spacing is unchanged.
- R9: A second wake event during recovery does not restart the count.
- R10: `rec_done` is high for exactly one cycle, in the first cycle that `bus_clk_en` is high after power-up or recovery.
- R11: A `stop_req` that arrives during power-up or recovery is ignored.
- R12: While `por_rst` is high, `bus_clk_en`, `rec_done` and `ovf_tick` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; all state changes on its falling edge |
| por_rst | input | 1 | Power-on reset, active high, synchronous |
| stop_req | input | 1 | One-cycle request to enter stop |
| wake_irq | input | 1 | Wake source: interrupt |
| wake_brk | input | 1 | Wake source: break request |
| ext_rst | input | 1 | External reset pin; wakes from stop only |
| short_rec | input | 1 | 1 selects the 32-cycle recovery, 0 the 4096-cycle one |
| bus_clk_en | output | 1 | High when bus clocks may run |
| rec_done | output | 1 | One-cycle pulse when a settle delay completes |
| ovf_tick | output | 1 | One-cycle pulse on each counter wrap |

## Verification
Embedded assertions check the following on every cycle:
- the tick and done pulses are one cycle wide;
- the done pulse coincides with the rising edge of the enable;
- stop drops the enable and suppresses the tick;
- a counter outside stop never stands still;
- the latched recovery selection stays fixed during recovery;
- recovery never falls back into stop.

Only the bench scenarios can show the lengths of the delays (4096 and 32 cycles), the spacing between ticks, and the effects of inputs that should change nothing. Those inputs are a late change of the option bit, a second wake, a stop request during recovery, and wake pulses while running. The bench's reference model counts down the remaining delay, compares its result on every clock, and checks each delay length explicitly.

// File: rtl/osr_pkg.sv
package osr_pkg;
  typedef enum logic [1:0] {
    ST_PWRUP = 2'd0,
    ST_RUN   = 2'd1,
    ST_STOP  = 2'd2,
    ST_RECOV = 2'd3
  } osr_state_e;
endpackage

// File: rtl/osr_counter.sv
module osr_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_tick
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(negedge clk) begin
    if (rst) begin
      cnt       <= '0;
      wrap_tick <= 1'b0;
    end else begin
      wrap_tick <= run && !clr && (cnt == CNT_MAX);
      if (clr)
        cnt <= '0;
      else if (run)
        cnt <= cnt + 1'b1;
    end
  end

  // R1: overflow tick never lasts two cycles
  p_tick_single_r1: assert property (@(negedge clk) disable iff (rst)
    wrap_tick |=> !wrap_tick);

  // R1: a running counter always moves
  p_count_moves_r1: assert property (@(negedge clk) disable iff (rst)
    (run && !clr) |=> (cnt != $past(cnt)));

  // R4: a halted counter holds its value
  p_halt_holds_r4: assert property (@(negedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(cnt));
endmodule

// File: rtl/osr_wake_gate.sv
module osr_wake_gate #(
  parameter int N_SRC = 3
) (
  input  logic [N_SRC-1:0] wake_src,
  input  logic             in_stop,
  output logic             wake_ok
);
  logic [N_SRC:0] any_chain;

  assign any_chain[0] = 1'b0;
  for (genvar g = 0; g < N_SRC; g++) begin : g_or
    assign any_chain[g+1] = any_chain[g] | wake_src[g];
  end

  // R8: events outside stop are discarded here
  assign wake_ok = in_stop & any_chain[N_SRC];
endmodule

// File: rtl/osr_ctrl.sv
module osr_ctrl
  import osr_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int SHORT_CNT = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_req,
  input  logic             wake_ok,
  input  logic             short_rec,
  input  logic [CNT_W-1:0] cnt,
  output osr_state_e       st,
  output logic             clr,
  output logic             run,
  output logic             bus_en,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CNT - 1);

  logic short_l;
  logic settling;
  logic expire;

  assign settling = (st == ST_PWRUP) || (st == ST_RECOV);
  assign expire   = settling && (short_l ? (cnt == SHORT_LAST) : (cnt == CNT_MAX));
  assign clr      = (st == ST_RUN) && stop_req;
  assign run      = (st != ST_STOP);

  always_ff @(negedge clk) begin
    if (rst) begin
      st      <= ST_PWRUP;
      short_l <= 1'b0;
      bus_en  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_PWRUP, ST_RECOV: begin
          if (expire) begin
            st     <= ST_RUN;
            bus_en <= 1'b1;
            done   <= 1'b1;
          end
        end
        ST_RUN: begin
          if (stop_req) begin
            st     <= ST_STOP;
            bus_en <= 1'b0;
          end
        end
        ST_STOP: begin
          if (wake_ok) begin
            st      <= ST_RECOV;
            short_l <= short_rec;
          end
        end
        default: st <= ST_PWRUP;
      endcase
    end
  end

  // R10: done marks the first enabled cycle only
  p_done_edge_r10: assert property (@(negedge clk) disable iff (rst)
    done |-> (bus_en && !$past(bus_en)));

  p_done_width_r10: assert property (@(negedge clk) disable iff (rst)
    done |=> !done);

  // R3: stop request while running drops the enable
  p_stop_drop_r3: assert property (@(negedge clk) disable iff (rst)
    (st == ST_RUN && stop_req) |=> (!bus_en && st == ST_STOP));

  // R7: latched option stays fixed through recovery
  p_short_hold_r7: assert property (@(negedge clk) disable iff (rst)
    (st == ST_RECOV) |=> (st != ST_RECOV || $stable(short_l)));

  // R9 / R11: recovery leaves only toward run
  p_recov_exit_r9: assert property (@(negedge clk) disable iff (rst)
    (st == ST_RECOV) |=> (st == ST_RECOV || st == ST_RUN));
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer
  import osr_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int SHORT_CNT = 32
) (
  input  logic osc_clk,
  input  logic por_rst,
  input  logic stop_req,
  input  logic wake_irq,
  input  logic wake_brk,
  input  logic ext_rst,
  input  logic short_rec,
  output logic bus_clk_en,
  output logic rec_done,
  output logic ovf_tick
);
  localparam int N_SRC = 3;

  osr_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic             clr;
  logic             run;
  logic             wake_ok;

  osr_wake_gate #(.N_SRC(N_SRC)) i_gate (
    .wake_src ({ext_rst, wake_brk, wake_irq}),
    .in_stop  (st == ST_STOP),
    .wake_ok  (wake_ok)
  );

  osr_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk       (osc_clk),
    .rst       (por_rst),
    .clr       (clr),
    .run       (run),
    .cnt       (cnt),
    .wrap_tick (ovf_tick)
  );

  osr_ctrl #(.CNT_W(CNT_W), .SHORT_CNT(SHORT_CNT)) i_ctrl (
    .clk       (osc_clk),
    .rst       (por_rst),
    .stop_req  (stop_req),
    .wake_ok   (wake_ok),
    .short_rec (short_rec),
    .cnt       (cnt),
    .st        (st),
    .clr       (clr),
    .run       (run),
    .bus_en    (bus_clk_en),
    .done      (rec_done)
  );

  // R4: stop keeps the tick and the enable low
  p_stop_quiet_r4: assert property (@(negedge osc_clk) disable iff (por_rst)
    (st == ST_STOP) |-> (!ovf_tick && !bus_clk_en));

  // R3: stop entry leaves the counter at zero
  p_stop_clears_r3: assert property (@(negedge osc_clk) disable iff (por_rst)
    clr |=> (cnt == '0));

  // R12: power-on reset clears every output
  p_reset_quiet_r12: assert property (@(negedge osc_clk)
    $past(por_rst) |-> (!bus_clk_en && !rec_done && !ovf_tick));
endmodule

// File: tb/test_osc_settle_timer.sv
module test_osc_settle_timer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic por_rst = 1'b1, stop_req = 1'b0, wake_irq = 1'b0, wake_brk = 1'b0;
  logic ext_rst = 1'b0, short_rec = 1'b0;
  logic bus_clk_en, rec_done, ovf_tick;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R12";
  bit    finished = 1'b0;

  osc_settle_timer i_osc_settle_timer (
    .osc_clk(clk), .por_rst(por_rst), .stop_req(stop_req),
    .wake_irq(wake_irq), .wake_brk(wake_brk), .ext_rst(ext_rst),
    .short_rec(short_rec), .bus_clk_en(bus_clk_en),
    .rec_done(rec_done), .ovf_tick(ovf_tick));

  // reference model: phase since clear, countdown to enable
  int m_phase = 0, m_remain = 4096;
  bit m_en = 0, m_done = 0, m_tick = 0, m_stopped = 0, m_valid = 0;

  always @(negedge clk) begin
    m_valid = 1;
    if (por_rst) begin
      m_phase = 0; m_remain = 4096; m_en = 0; m_done = 0; m_tick = 0; m_stopped = 0;
    end else begin
      m_done = 0; m_tick = 0;
      if (m_stopped) begin
        if (wake_irq || wake_brk || ext_rst) begin
          m_stopped = 0;
          m_remain  = short_rec ? 32 : 4096;
        end
      end else if (m_en && stop_req) begin
        m_stopped = 1; m_en = 0; m_phase = 0;
      end else begin
        m_phase = (m_phase + 1) % 4096;
        if (m_phase == 0) m_tick = 1;
        if (!m_en) begin
          m_remain--;
          if (m_remain == 0) begin m_en = 1; m_done = 1; end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (m_valid && !finished) begin
      chk(bus_clk_en === m_en,  cur_req, "model bus_clk_en", int'(bus_clk_en), int'(m_en));
      chk(rec_done   === m_done, cur_req, "model rec_done",  int'(rec_done),   int'(m_done));
      chk(ovf_tick   === m_tick, cur_req, "model ovf_tick",  int'(ovf_tick),   int'(m_tick));
    end
  end

  task automatic wait_en(output int n);
    n = 0;
    forever begin
      @(posedge clk); n++;
      if (bus_clk_en === 1'b1 || n > 5000) break;
    end
  endtask

  task automatic enter_stop();
    @(posedge clk); stop_req = 1'b1;
    @(posedge clk); stop_req = 1'b0;
    repeat (20) @(posedge clk);
  endtask

  // src: 0 irq, 1 brk, 2 ext_rst; act: 1 flip option, 2 second wake, 3 stop request
  task automatic recover(input bit sh, input int src, input int act_at,
                         input int act, output int n);
    @(posedge clk);
    short_rec = sh;
    case (src)
      0: wake_irq = 1'b1;
      1: wake_brk = 1'b1;
      default: ext_rst = 1'b1;
    endcase
    n = 0;
    forever begin
      @(posedge clk); n++;
      if (bus_clk_en === 1'b1 || n > 5000) break;
      if (n == 1) begin wake_irq = 0; wake_brk = 0; ext_rst = 0; end
      if (n == act_at) begin
        case (act)
          1: short_rec = ~short_rec;
          2: wake_irq = 1'b1;
          default: stop_req = 1'b1;
        endcase
      end
      if (n == act_at + 1) begin wake_irq = 1'b0; stop_req = 1'b0; end
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int n;
    bit bad;
    repeat (5) @(posedge clk);
    // R12: reset state
    chk(bus_clk_en === 0, "R12", "bus_clk_en in reset", int'(bus_clk_en), 0);
    chk(rec_done === 0,   "R12", "rec_done in reset",   int'(rec_done), 0);
    chk(ovf_tick === 0,   "R12", "ovf_tick in reset",   int'(ovf_tick), 0);

    // R2: full power-up delay, option bit ignored
    cur_req = "R2"; short_rec = 1'b1;
    @(posedge clk); por_rst = 1'b0;
    wait_en(n);
    chk(n == 4096, "R2", "power-up delay", n, 4096);
    chk(rec_done === 1, "R10", "done at enable", int'(rec_done), 1);
    @(posedge clk);
    chk(rec_done === 0, "R10", "done width", int'(rec_done), 0);

    // R1 / R8: tick spacing with wake pulses while running
    cur_req = "R1";
    do @(posedge clk); while (ovf_tick !== 1'b1);
    n = 0; bad = 0;
    forever begin
      @(posedge clk); n++;
      if (bus_clk_en !== 1'b1) bad = 1;
      if (ovf_tick === 1'b1 || n > 5000) break;
      if (n == 100) ext_rst = 1'b1;
      if (n == 101) ext_rst = 1'b0;
      if (n == 200) wake_irq = 1'b1;
      if (n == 201) wake_irq = 1'b0;
      if (n == 300) wake_brk = 1'b1;
      if (n == 301) wake_brk = 1'b0;
    end
    chk(n == 4096, "R1", "tick spacing", n, 4096);
    chk(!bad, "R8", "enable kept under stray wake", int'(bad), 0);

    // R3 / R4: stop entry and quiet stop
    cur_req = "R3";
    @(posedge clk); stop_req = 1'b1;
    @(posedge clk);
    chk(bus_clk_en === 0, "R3", "enable after stop", int'(bus_clk_en), 0);
    stop_req = 1'b0;
    cur_req = "R4"; bad = 0;
    repeat (200) begin
      @(posedge clk);
      if (ovf_tick !== 1'b0 || bus_clk_en !== 1'b0) bad = 1;
    end
    chk(!bad, "R4", "quiet during stop", int'(bad), 0);

    // R5: short recovery
    cur_req = "R5";
    recover(1'b1, 0, 0, 0, n);
    chk(n == 33, "R5", "short recovery", n, 33);
    chk(rec_done === 1, "R10", "done after short", int'(rec_done), 1);

    // R6: full recovery, coincident tick
    enter_stop(); cur_req = "R6";
    recover(1'b0, 1, 0, 0, n);
    chk(n == 4097, "R6", "full recovery", n, 4097);
    chk(ovf_tick === 1, "R6", "tick at full recovery", int'(ovf_tick), 1);

    // R7: option change after wake has no effect
    enter_stop(); cur_req = "R7";
    recover(1'b1, 2, 5, 1, n);
    chk(n == 33, "R7", "short kept after flip", n, 33);
    enter_stop();
    recover(1'b0, 0, 5, 1, n);
    chk(n == 4097, "R7", "full kept after flip", n, 4097);

    // R9: second wake during recovery
    enter_stop(); cur_req = "R9";
    recover(1'b1, 0, 10, 2, n);
    chk(n == 33, "R9", "no restart on second wake", n, 33);

    // R11: stop request during recovery
    enter_stop(); cur_req = "R11";
    recover(1'b1, 1, 5, 3, n);
    chk(n == 33, "R11", "stop ignored in recovery", n, 33);

    repeat (3) @(posedge clk);
    summary();
  end
endmodule